// File: doc/BRIEF.md
# Disciplined Pulse-Per-Second Flywheel

This block produces a once-per-second tick inside the fabric by counting clock cycles of a fabric clock that is itself the sample clock divided down. It does not pass the external timing pulse through. Instead it uses that pulse once per alignment. After reset, or after a rearm request, the block waits in an armed state. The first rising edge seen on sync lane 0 re-phases its cycle counter, and from then on the counter runs on its own as a flywheel. Later external edges never move its phase.

While it is locked, the block compares every later external rising edge with its own tick. An edge that lands on any other phase increments a saturating error count. This gives the system a cheap way to notice drift, or a wrong alignment, without disturbing the timebase. Any fixed delay between the external pulse and the tick is a constant that offline calibration removes.

The default terminal count is 100·2^21 cycles. That is one second for a sample clock of 100·2^23 Hz divided by four.

Top module: `pps_flywheel`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release, `armed_o` is 1, `locked_o` is 0, `tick_o` is 0 and `err_cnt_o` is 0.
- R2: While armed (waiting for alignment), `tick_o` stays 0, whatever the counter would otherwise produce.
- R3: A rising edge on `pps_in_i` is recognised when the input is sampled 1 on a clock edge after being sampled 0 on the previous one. While armed, the clock edge after that recognition sets `locked_o` to 1, clears `armed_o`, and reloads the counter to zero. `tick_o` is 1 in that same cycle.
- R4: While locked, `tick_o` is 1 for exactly one cycle in every `CYCLES_PER_SEC` cycles, with or without external edges.
- R5: While locked, external edges never shift the phase of `tick_o`.
- R6: While locked, a recognised external edge coincides with the tick when `tick_o` is 1 in the following cycle. A coinciding edge leaves `err_cnt_o` unchanged. Any other recognised edge raises `err_cnt_o` by one, visible one cycle after the recognition.
- R7: `err_cnt_o` saturates at 2^`ERR_W`−1 and holds there on further mismatches.
- R8: A cycle with `rearm_i` high returns the block to the armed state on the next clock edge. It clears the lock and `err_cnt_o`, and the ticks stop.
- R9: `rearm_i` takes priority over alignment. An edge recognised in a cycle where `rearm_i` is high does not lock the block.
- R10: A level held high on `pps_in_i` counts as one edge only. It cannot re-align the block until the input has returned low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock, derived from the sample clock |
| rst_n | input | 1 | Synchronous active-low reset; also arms the block |
| rearm_i | input | 1 | Software rearm request, one cycle or longer |
| pps_in_i | input | 1 | External pulse-per-second level from sync lane 0 |
| tick_o | output | 1 | Internal one-cycle second tick |
| armed_o | output | 1 | 1 while waiting for the aligning edge |
| locked_o | output | 1 | 1 once aligned and free-running |
| err_cnt_o | output | ERR_W | Saturating count of non-coinciding external edges |

## Verification
The input passes one register before edge recognition, so an edge on `pps_in_i` first has an effect on the clock edge after the one that samples it high. The lock and the first tick appear two cycles after the input first reads high. An error increment follows one cycle later than recognition, and a rearm acts on the very next edge. The stimulus table is built from these latencies: inputs are driven on the falling edge, and each row's outputs are compared on the next falling edge, so each expected value belongs to exactly one rising edge. A short `CYCLES_PER_SEC` of 4 lets match, mismatch, saturation and free-running phases each appear within a few rows.

// File: rtl/pps_pkg.sv
// Shared types for the pulse-per-second flywheel.
package pps_pkg;
    // Alignment state: waiting for an external edge, or free-running.
    typedef enum logic {
        ST_ARMED  = 1'b0,
        ST_LOCKED = 1'b1
    } pps_state_t;
endpackage

// File: rtl/pps_edge_det.sv
// Rising-edge recogniser for the external pulse level.
// Assumes the input is already synchronous to clk (the upstream capture
// registers handle the crossing). One register stage, then a compare
// with the previous sample.
module pps_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic samp_q;
    logic prev_q;

    // Capture the level and keep the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            samp_q <= level_i;
            prev_q <= samp_q;
        end
    end

    // A rise is a high sample after a low one.
    always_comb rise_o = samp_q & ~prev_q;
endmodule

// File: rtl/pps_phase_ctrl.sv
// Arm/lock controller. Reset leaves it armed. A recognised edge while
// armed locks it and requests a counter reload. A rearm request always
// wins and returns it to armed.
module pps_phase_ctrl
    import pps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rearm_i,
    input  logic       rise_i,
    output pps_state_t state_o,
    output logic       align_o
);
    pps_state_t state_q;

    // Alignment happens only while armed, on an edge, without a rearm.
    always_comb align_o = (state_q == ST_ARMED) && rise_i && !rearm_i;

    // State register with rearm priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= ST_ARMED;
        else if (rearm_i) state_q <= ST_ARMED;
        else if (align_o) state_q <= ST_LOCKED;
    end

    // Expose the state to the datapath.
    always_comb state_o = state_q;
endmodule

// File: rtl/pps_sec_counter.sv
// Cycles-per-second counter. Reloads to zero on align and wraps at
// PERIOD-1 while running. Assumes PERIOD >= 2.
module pps_sec_counter #(
    parameter int PERIOD = 209715200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic align_i,
    input  logic run_i,
    output logic at_zero_o,
    output logic at_last_o
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    // Reload on alignment, otherwise count and wrap while running.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (align_i) cnt_q <= '0;
        else if (run_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // Phase markers for the tick and for the coincidence test.
    always_comb begin
        at_zero_o = (cnt_q == '0);
        at_last_o = (cnt_q == LAST);
    end
endmodule

// File: rtl/pps_err_count.sv
// Saturating counter of edges that miss the internal tick. Cleared
// synchronously. Assumes W >= 1.
module pps_err_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_q;

    // Clear has priority; increment stops at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (clr_i)                    cnt_q <= '0;
        else if (inc_i && cnt_q != MAXV)   cnt_q <= cnt_q + 1'b1;
    end

    // Drive the output.
    always_comb cnt_o = cnt_q;
endmodule

// File: rtl/pps_flywheel.sv
// Pulse-per-second flywheel top. Aligns an internal second counter to
// the first external edge after arming, then free-runs and counts
// external edges that do not coincide with its own tick.
// Assumes pps_in_i is synchronous to clk and CYCLES_PER_SEC >= 2.
module pps_flywheel
    import pps_pkg::*;
#(
    parameter int CYCLES_PER_SEC = 209715200,
    parameter int ERR_W          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rearm_i,
    input  logic             pps_in_i,
    output logic             tick_o,
    output logic             armed_o,
    output logic             locked_o,
    output logic [ERR_W-1:0] err_cnt_o
);
    logic       rise;
    logic       align;
    logic       at_zero;
    logic       at_last;
    logic       miss;
    pps_state_t state;

    pps_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pps_in_i),
        .rise_o  (rise)
    );

    pps_phase_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rearm_i (rearm_i),
        .rise_i  (rise),
        .state_o (state),
        .align_o (align)
    );

    pps_sec_counter #(.PERIOD(CYCLES_PER_SEC)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .align_i   (align),
        .run_i     (state == ST_LOCKED),
        .at_zero_o (at_zero),
        .at_last_o (at_last)
    );

    // An edge in lock misses unless it is seen on the last count.
    always_comb miss = (state == ST_LOCKED) && rise && !at_last && !rearm_i;

    pps_err_count #(.W(ERR_W)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (rearm_i),
        .inc_i (miss),
        .cnt_o (err_cnt_o)
    );

    // Status and tick outputs.
    always_comb begin
        armed_o  = (state == ST_ARMED);
        locked_o = (state == ST_LOCKED);
        tick_o   = (state == ST_LOCKED) && at_zero;
    end
endmodule

// File: rtl/pps_flywheel_chk.sv
// Property checker for pps_flywheel, attached by bind.
module pps_flywheel_chk #(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rearm_i,
    input logic             tick_o,
    input logic             armed_o,
    input logic             locked_o,
    input logic [ERR_W-1:0] err_cnt_o
);
    localparam logic [ERR_W-1:0] MAXV = '1;

    // R2
    no_tick_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |-> !tick_o);

    // R3
    tick_on_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> tick_o);

    // R4
    single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R5
    stay_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !rearm_i) |=> locked_o);

    // R6
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rearm_i |=> (err_cnt_o == $past(err_cnt_o)
                      || err_cnt_o == ERR_W'($past(err_cnt_o) + 1'b1)));

    // R7
    err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt_o == MAXV && !rearm_i) |=> err_cnt_o == MAXV);

    // R8
    rearm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> (armed_o && !locked_o && err_cnt_o == '0));
endmodule

bind pps_flywheel pps_flywheel_chk #(.ERR_W(ERR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rearm_i   (rearm_i),
    .tick_o    (tick_o),
    .armed_o   (armed_o),
    .locked_o  (locked_o),
    .err_cnt_o (err_cnt_o)
);

// File: tb/test_pps_flywheel.sv
module test_pps_flywheel;
    localparam int P  = 4;
    localparam int EW = 2;
    localparam int NV = 38;

    // Row: {pps, rearm, exp_tick, exp_armed, exp_locked, exp_err[1:0]}
    localparam logic [6:0] VEC [NV] = '{
        7'b0001000, 7'b1001000, 7'b1010100, 7'b0000100, 7'b0000100,
        7'b1000100, 7'b1010100, 7'b0000100, 7'b1000100, 7'b0000101,
        7'b0010101, 7'b1000101, 7'b0000110, 7'b1000110, 7'b0010110,
        7'b1000110, 7'b0000111, 7'b0000111, 7'b0010111, 7'b1000111,
        7'b0000111, 7'b0101000, 7'b0001000, 7'b0001000, 7'b1001000,
        7'b1010100, 7'b0000100, 7'b0000100, 7'b0000100, 7'b0010100,
        7'b0000100, 7'b0101000, 7'b1101000, 7'b1101000, 7'b1001000,
        7'b0001000, 7'b1001000, 7'b1010100
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rearm_i = 1'b0;
    logic          pps_in_i = 1'b0;
    logic          tick_o;
    logic          armed_o;
    logic          locked_o;
    logic [EW-1:0] err_cnt_o;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pps_flywheel #(.CYCLES_PER_SEC(P), .ERR_W(EW)) i_pps_flywheel (
        .clk       (clk),
        .rst_n     (rst_n),
        .rearm_i   (rearm_i),
        .pps_in_i  (pps_in_i),
        .tick_o    (tick_o),
        .armed_o   (armed_o),
        .locked_o  (locked_o),
        .err_cnt_o (err_cnt_o)
    );

    function automatic string tag_of(int i);
        if (i < 2)  return "R2";
        if (i < 3)  return "R3";
        if (i < 8)  return "R4";
        if (i < 9)  return "R6";
        if (i < 11) return "R5";
        if (i < 15) return "R6";
        if (i < 21) return "R7";
        if (i < 25) return "R8";
        if (i < 31) return "R4";
        if (i < 34) return "R9";
        return "R10";
    endfunction

    task automatic expect_out(string req, logic t, logic a, logic l, logic [EW-1:0] e);
        n_cmp++;
        if (tick_o !== t || armed_o !== a || locked_o !== l || err_cnt_o !== e) begin
            n_fail++;
            $display("FAIL %s: got tick=%b armed=%b locked=%b err=%0d, expected tick=%b armed=%b locked=%b err=%0d",
                     req, tick_o, armed_o, locked_o, err_cnt_o, t, a, l, e);
        end
    endtask

    initial begin
        // R1: reset state, during reset and just after release
        repeat (3) @(negedge clk);
        expect_out("R1", 1'b0, 1'b1, 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1", 1'b0, 1'b1, 1'b0, '0);

        // Table walk: drive on the falling edge, compare on the next one
        for (int i = 0; i < NV; i++) begin
            pps_in_i = VEC[i][6];
            rearm_i  = VEC[i][5];
            @(negedge clk);
            expect_out(tag_of(i), VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1:0]);
        end

        // R1: reset in the middle of lock re-arms and clears the error count
        pps_in_i = 1'b0;
        rearm_i  = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        expect_out("R1", 1'b0, 1'b1, 1'b0, '0);
        rst_n = 1'b1;

        // R4: a full period with no external edge gives exactly one tick
        pps_in_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        expect_out("R3", 1'b1, 1'b0, 1'b1, '0);
        pps_in_i = 1'b0;
        for (int k = 1; k < P; k++) begin
            @(negedge clk);
            expect_out("R4", 1'b0, 1'b0, 1'b1, '0);
        end
        @(negedge clk);
        expect_out("R4", 1'b1, 1'b0, 1'b1, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule